// File: doc/BRIEF.md
# Serial NAND Page Reader with Row Cache

This block turns a host read request (byte address plus byte count) into the byte-level command traffic needed to fetch data from a serial NAND device whose pages hold 2048 bytes, and returns the data as a byte stream. The request is cut into chunks that never cross a page. For each chunk the block consults an external bad-block lookup, loads the page into the device's internal cache when needed, polls the device status until the operation finishes, grades the ECC outcome, and then reads bytes out of the cache starting at the requested column.

The block keeps the row of the page most recently loaded. A chunk on that same row goes straight to the cache read. The remembered row is held in a register one bit wider than a row, so its reset value never matches any real row, including the last one. A one-cycle notification from the write path (program, erase or mark-bad) clears the remembered row. Serial shifting is done by a separate shifter behind a one-byte exchange port. Bad-block storage lives outside the block as well.

The host side takes a request with valid/ready. The data side is valid/ready: `out_valid` stays high and `out_data` stays unchanged until `out_ready` is sampled high, and the block fetches no further byte while one is waiting. Each request ends with a one-cycle `done` pulse that carries a status code.

Top module: `nand_page_reader`

## Requirements
- R1: The byte address splits into row = address >> 11 and column = address[10:0]. A page load is the four-byte frame 0x13, 0x00, row[15:8], row[7:0], and `xfer_last` is set only on the fourth byte.
- R2: After a page load the block polls with the frame 0x0F, 0xC0, 0x00, marking the third byte last and taking its response as the status byte. Status bit 0 set means busy, and the block polls again. After 100 polls that all return busy, the request ends with status 5 (timeout) and the remembered row is cleared.
- R3: Status bits 5:4 equal to 1 mean the device corrected the data. The read continues, and the final status is 1 (corrected) unless a later chunk ends the request with an error.
- R4: Status bits 5:4 equal to 2 mean the data could not be corrected. The request ends at once with status 2 and no cache read of that page, and the remembered row is cleared, so the next read of that row loads it again.
- R5: A cache read is the frame 0x03, {5'b0, column[10:8]}, column[7:0], 0x00, followed by one exchange per data byte. `xfer_last` is set on the final data byte of the chunk only.
- R6: The first chunk holds min(length, 2048 − column) bytes. Each later chunk starts at column 0 of the next row. Bytes come out in address order. A request that finishes cleanly ends with status 0.
- R7: A chunk whose row equals the remembered row sends no page-load or poll frame.
- R8: Before each chunk the block drives `bb_blk` = row >> 6. If `bb_bad` is high, the request ends with status 3 and that chunk sends no bytes.
- R9: After reset, and after any cycle with `inv_row` high, the next chunk always loads its page. This includes the last row, whose value is all ones.
- R10: A zero-length request sets `done` with status 0 in the cycle after it is accepted. A request with address + length > 2^27 does the same with status 4. Neither sends any exchange.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle.
- R12: The block offers `xfer_valid` and holds it, along with `xfer_tx` and `xfer_last`, until `xfer_ready`. It offers no further byte until `rx_valid` has returned the response to the previous one.
- R13: `req_ready` is high only when the block is idle. After reset it is high, and `done`, `xfer_valid` and `out_valid` are low. `done` lasts exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_addr | input | 27 | Starting byte address |
| req_len | input | 16 | Byte count |
| out_valid | output | 1 | Data byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Data byte |
| done | output | 1 | One-cycle end-of-request pulse |
| done_status | output | 3 | 0 clean, 1 corrected, 2 uncorrectable, 3 bad block, 4 out of range, 5 timeout |
| inv_row | input | 1 | Program, erase or mark-bad happened; forget the remembered row |
| bb_blk | output | 10 | Block number being checked |
| bb_bad | input | 1 | That block is marked bad |
| xfer_valid | output | 1 | Byte offered to the shifter |
| xfer_ready | input | 1 | Shifter takes the byte |
| xfer_tx | output | 8 | Byte to send |
| xfer_last | output | 1 | Chip select ends after this byte |
| rx_valid | input | 1 | Response byte of the last exchange |
| rx_data | input | 8 | Response byte |

## Verification
The bench targets the remembered row. It reads the all-ones last row straight after reset, where a plain all-ones sentinel would skip the load and return stale data. It reads the same row again after an invalidate pulse, and again after an uncorrectable result. A design that forgot to clear the row would show zero page loads where one is expected. Requests that start a few bytes before a page boundary, or that run into an uncorrectable page partway through, expose a wrong chunk length or a missing abort through the byte count and the returned status. Other stimulus checks the range boundary one byte either side of the device end, a device stuck busy that must hit the poll limit, and the random stall patterns on both handshakes, which would expose a byte that gets dropped or repeated.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  localparam logic [7:0] OP_PAGE_LOAD = 8'h13;
  localparam logic [7:0] OP_FEATURE_RD = 8'h0F;
  localparam logic [7:0] FEAT_STATUS  = 8'hC0;
  localparam logic [7:0] OP_CACHE_RD  = 8'h03;

  typedef enum logic [2:0] {
    RS_CLEAN   = 3'd0,
    RS_FIXED   = 3'd1,
    RS_UNFIXED = 3'd2,
    RS_BADBLK  = 3'd3,
    RS_RANGE   = 3'd4,
    RS_TIMEOUT = 3'd5
  } rd_status_e;

  typedef enum logic [3:0] {
    F_IDLE, F_CHECK, F_LOAD, F_POLL, F_EVAL, F_HDR, F_DATA, F_OUT, F_NEXT
  } rd_state_e;

  typedef enum logic [1:0] {
    X_IDLE, X_SEND, X_WAIT
  } xfer_state_e;
endpackage

// File: rtl/nand_byte_link.sv
module nand_byte_link
  import nand_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] go_byte,
  input  logic       go_last,
  output logic       ldone,
  output logic [7:0] ldata,
  output logic       xfer_valid,
  input  logic       xfer_ready,
  output logic [7:0] xfer_tx,
  output logic       xfer_last,
  input  logic       rx_valid,
  input  logic [7:0] rx_data
);
  xfer_state_e st;
  logic [7:0]  tx_q;
  logic        last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= X_IDLE;
      tx_q   <= 8'h00;
      last_q <= 1'b0;
    end else begin
      unique case (st)
        X_IDLE: if (go) begin
          tx_q   <= go_byte;
          last_q <= go_last;
          st     <= X_SEND;
        end
        X_SEND: if (xfer_ready) st <= X_WAIT;
        X_WAIT: if (rx_valid) st <= X_IDLE;
        default: st <= X_IDLE;
      endcase
    end
  end

  assign xfer_valid = (st == X_SEND);
  assign xfer_tx    = tx_q;
  assign xfer_last  = last_q;
  assign ldone      = (st == X_WAIT) && rx_valid;
  assign ldata      = rx_data;

  // R12: offered byte held until taken
  a_r12_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_tx) && $stable(xfer_last));
  // R12: the sequencer only starts a byte when nothing is in flight
  a_r12_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> st == X_IDLE);
endmodule

// File: rtl/nand_row_cache.sv
module nand_row_cache #(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] row,
  input  logic             set_en,
  input  logic             kill,
  output logic             hit
);
  // extra top bit: set means "no row remembered", never equal to a real row
  logic [ROW_W:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held <= '1;
    else if (kill)   held <= '1;
    else if (set_en) held <= {1'b0, row};
  end

  assign hit = (held == {1'b0, row});

  // R9: a clear leaves nothing that can match
  a_r9_kill_forgets: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> held[ROW_W]);
  // R7: a stored row is recognised on the next cycle
  a_r7_set_hits: assert property (@(posedge clk) disable iff (!rst_n)
    set_en && !kill |=> !held[ROW_W]);
endmodule

// File: rtl/nand_span_calc.sv
module nand_span_calc #(
  parameter int ADDR_W = 27,
  parameter int LEN_W  = 16,
  parameter int COL_W  = 11
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [COL_W-1:0]  col,
  input  logic [LEN_W-1:0]  len_left,
  output logic              too_far,
  output logic [COL_W:0]    chunk
);
  localparam int PAGE = 1 << COL_W;

  logic [ADDR_W:0] end_w;
  logic [COL_W:0]  room;
  logic            clip;

  assign end_w   = {1'b0, req_addr} + (ADDR_W+1)'(req_len);
  assign too_far = end_w > {1'b1, {ADDR_W{1'b0}}};

  assign room  = (COL_W+1)'(PAGE) - {1'b0, col};
  assign clip  = len_left > LEN_W'(room);
  assign chunk = clip ? room : len_left[COL_W:0];
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nand_rd_pkg::*;
#(
  parameter int ADDR_W    = 27,
  parameter int LEN_W     = 16,
  parameter int COL_W     = 11,
  parameter int BLK_SHIFT = 6,
  parameter int POLL_MAX  = 100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [LEN_W-1:0]              req_len,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [7:0]                    out_data,
  output logic                          done,
  output logic [2:0]                    done_status,
  input  logic                          inv_row,
  output logic [ADDR_W-COL_W-BLK_SHIFT-1:0] bb_blk,
  input  logic                          bb_bad,
  output logic                          xfer_valid,
  input  logic                          xfer_ready,
  output logic [7:0]                    xfer_tx,
  output logic                          xfer_last,
  input  logic                          rx_valid,
  input  logic [7:0]                    rx_data
);
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int PW    = $clog2(POLL_MAX + 1);

  rd_state_e        st;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [LEN_W-1:0] len_left;
  logic [COL_W:0]   chunk_left;
  logic [1:0]       idx;
  logic             pend;
  logic             busy_q;
  logic [1:0]       ecc_q;
  logic [PW-1:0]    polls;
  logic             fixed_q;
  logic             done_q;
  rd_status_e       dstat_q;
  logic             ov_q;
  logic [7:0]       od_q;

  logic             too_far;
  logic [COL_W:0]   chunk;
  logic             hit, cache_set, cache_kill, poll_limit;
  logic             lnk_go, ldone, byte_st, tx_last;
  logic [7:0]       ldata, tx_byte;
  logic [15:0]      row16, col16;

  nand_span_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .COL_W(COL_W)) u_span (
    .req_addr(req_addr), .req_len(req_len), .col(col_q), .len_left(len_left),
    .too_far(too_far), .chunk(chunk));

  assign poll_limit = (polls == PW'(POLL_MAX - 1));
  assign cache_set  = (st == F_EVAL) && !busy_q && (ecc_q != 2'd2);
  assign cache_kill = inv_row || ((st == F_EVAL) && ((busy_q && poll_limit) || (!busy_q && ecc_q == 2'd2)));

  nand_row_cache #(.ROW_W(ROW_W)) u_cache (
    .clk(clk), .rst_n(rst_n), .row(row_q), .set_en(cache_set), .kill(cache_kill), .hit(hit));

  assign row16 = 16'(row_q);
  assign col16 = 16'(col_q);

  always_comb begin
    tx_byte = 8'h00;
    tx_last = 1'b0;
    unique case (st)
      F_LOAD: unique case (idx)
        2'd0: tx_byte = OP_PAGE_LOAD;
        2'd1: tx_byte = 8'h00;
        2'd2: tx_byte = row16[15:8];
        default: begin tx_byte = row16[7:0]; tx_last = 1'b1; end
      endcase
      F_POLL: unique case (idx)
        2'd0: tx_byte = OP_FEATURE_RD;
        2'd1: tx_byte = FEAT_STATUS;
        default: tx_last = 1'b1;
      endcase
      F_HDR: unique case (idx)
        2'd0: tx_byte = OP_CACHE_RD;
        2'd1: tx_byte = col16[15:8];
        2'd2: tx_byte = col16[7:0];
        default: tx_byte = 8'h00;
      endcase
      F_DATA: tx_last = (chunk_left == (COL_W+1)'(1));
      default: ;
    endcase
  end

  assign byte_st = (st == F_LOAD) || (st == F_POLL) || (st == F_HDR) || (st == F_DATA);
  assign lnk_go  = byte_st && !pend;

  nand_byte_link u_link (
    .clk(clk), .rst_n(rst_n), .go(lnk_go), .go_byte(tx_byte), .go_last(tx_last),
    .ldone(ldone), .ldata(ldata),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_tx(xfer_tx), .xfer_last(xfer_last),
    .rx_valid(rx_valid), .rx_data(rx_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= F_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      len_left   <= '0;
      chunk_left <= '0;
      idx        <= '0;
      pend       <= 1'b0;
      busy_q     <= 1'b0;
      ecc_q      <= 2'd0;
      polls      <= '0;
      fixed_q    <= 1'b0;
      done_q     <= 1'b0;
      dstat_q    <= RS_CLEAN;
      ov_q       <= 1'b0;
      od_q       <= 8'h00;
    end else begin
      done_q <= 1'b0;
      if (lnk_go) pend <= 1'b1;
      if (ldone)  pend <= 1'b0;
      unique case (st)
        F_IDLE: if (req_valid) begin
          row_q    <= req_addr[ADDR_W-1:COL_W];
          col_q    <= req_addr[COL_W-1:0];
          len_left <= req_len;
          fixed_q  <= 1'b0;
          if (req_len == '0) begin
            done_q <= 1'b1; dstat_q <= RS_CLEAN;
          end else if (too_far) begin
            done_q <= 1'b1; dstat_q <= RS_RANGE;
          end else begin
            st <= F_CHECK;
          end
        end
        F_CHECK: begin
          chunk_left <= chunk;
          idx        <= '0;
          polls      <= '0;
          if (bb_bad) begin
            done_q <= 1'b1; dstat_q <= RS_BADBLK; st <= F_IDLE;
          end else if (hit) st <= F_HDR;
          else st <= F_LOAD;
        end
        F_LOAD: if (ldone) begin
          if (idx == 2'd3) begin idx <= '0; st <= F_POLL; end
          else idx <= idx + 2'd1;
        end
        F_POLL: if (ldone) begin
          if (idx == 2'd2) begin
            busy_q <= ldata[0];
            ecc_q  <= ldata[5:4];
            idx    <= '0;
            st     <= F_EVAL;
          end else idx <= idx + 2'd1;
        end
        F_EVAL: begin
          if (busy_q) begin
            if (poll_limit) begin
              done_q <= 1'b1; dstat_q <= RS_TIMEOUT; st <= F_IDLE;
            end else begin
              polls <= polls + PW'(1); st <= F_POLL;
            end
          end else if (ecc_q == 2'd2) begin
            done_q <= 1'b1; dstat_q <= RS_UNFIXED; st <= F_IDLE;
          end else begin
            if (ecc_q == 2'd1) fixed_q <= 1'b1;
            st <= F_HDR;
          end
        end
        F_HDR: if (ldone) begin
          if (idx == 2'd3) begin idx <= '0; st <= F_DATA; end
          else idx <= idx + 2'd1;
        end
        F_DATA: if (ldone) begin
          od_q <= ldata;
          ov_q <= 1'b1;
          st   <= F_OUT;
        end
        F_OUT: if (out_ready) begin
          ov_q       <= 1'b0;
          chunk_left <= chunk_left - (COL_W+1)'(1);
          len_left   <= len_left - LEN_W'(1);
          st         <= (chunk_left == (COL_W+1)'(1)) ? F_NEXT : F_DATA;
        end
        F_NEXT: begin
          if (len_left == '0) begin
            done_q  <= 1'b1;
            dstat_q <= fixed_q ? RS_FIXED : RS_CLEAN;
            st      <= F_IDLE;
          end else begin
            row_q <= row_q + ROW_W'(1);
            col_q <= '0;
            st    <= F_CHECK;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == F_IDLE);
  assign out_valid   = ov_q;
  assign out_data    = od_q;
  assign done        = done_q;
  assign done_status = dstat_q;
  assign bb_blk      = row_q[ROW_W-1:BLK_SHIFT];

  // R11: stalled byte stays put
  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R10: immediate completions start no exchange
  a_r10_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_len == '0 || too_far) |=> !xfer_valid && done);
  // R2: poll counter never passes its limit
  a_r2_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    polls < PW'(POLL_MAX));
  // R8: a flagged block ends the request without an exchange
  a_r8_bad_stops: assert property (@(posedge clk) disable iff (!rst_n)
    st == F_CHECK && bb_bad |=> req_ready && done && !xfer_valid);
  // R13: done lasts one cycle
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_nand_page_reader.sv
`timescale 1ns/1ps
module tb_nand_page_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [26:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        done;
  logic [2:0]  done_status;
  logic        inv_row = 1'b0;
  logic [9:0]  bb_blk;
  logic        bb_bad;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [7:0]  xfer_tx;
  logic        xfer_last;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;

  always #4 clk = ~clk;

  nand_page_reader dut (.*);

  localparam int STUCK_ROW = 9, FIX_ROW = 3, BADECC_ROW = 5;
  assign bb_bad = (bb_blk == 10'd2) || (bb_blk == 10'd700);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  function automatic logic [7:0] pat(input int row, input int col);
    return 8'(row * 13 + col * 7 + (col >> 8));
  endfunction
  function automatic int ecc_of(input int row);
    return (row == BADECC_ROW) ? 2 : (row == FIX_ROW) ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- device and shifter model ----------------
  int n_load = 0, n_xfer = 0, ferr_ld = 0, ferr_pl = 0, ferr_rd = 0, r12_err = 0;
  int fidx = 0, m_row = 0, rcol = 0, busy_left = 0, rsp_dly = 0;
  logic [7:0] fop = 8'h00, hi = 8'h00, rsp_byte = 8'h00;
  bit rsp_pend = 0, inflight = 0;

  always @(posedge clk) begin
    logic [7:0] r;
    rx_valid   <= 1'b0;
    xfer_ready <= ($urandom % 4) != 0;
    out_ready  <= ($urandom % 4) != 0;
    if (rsp_pend) begin
      if (rsp_dly == 0) begin
        rx_valid <= 1'b1; rx_data <= rsp_byte; rsp_pend = 0; inflight = 0;
      end else rsp_dly = rsp_dly - 1;
    end
    if (xfer_valid && xfer_ready) begin
      if (inflight) r12_err++;
      r = 8'h00;
      if (fidx == 0) fop = xfer_tx;
      case (fop)
        8'h13: begin
          if (fidx == 1 && xfer_tx != 8'h00) ferr_ld++;
          if (fidx == 2) hi = xfer_tx;
          if (fidx == 3) begin m_row = {hi, xfer_tx}; n_load++; busy_left = $urandom % 3; end
          if (xfer_last != (fidx == 3)) ferr_ld++;
        end
        8'h0F: begin
          if (fidx == 1 && xfer_tx != 8'hC0) ferr_pl++;
          if (xfer_last != (fidx == 2)) ferr_pl++;
          if (fidx == 2) begin
            if (m_row == STUCK_ROW) r = 8'h01;
            else if (busy_left > 0) begin busy_left--; r = 8'h01; end
            else r = {2'b00, 2'(ecc_of(m_row)), 4'h0};
          end
        end
        8'h03: begin
          if (fidx == 1) hi = xfer_tx;
          if (fidx == 2) rcol = {hi[2:0], xfer_tx};
          if (fidx <= 3 && xfer_last) ferr_rd++;
          if (fidx >= 4) r = pat(m_row, rcol + fidx - 4);
        end
        default: ferr_rd++;
      endcase
      n_xfer++;
      fidx = xfer_last ? 0 : fidx + 1;
      rsp_byte = r; rsp_dly = $urandom % 2; rsp_pend = 1; inflight = 1;
    end
  end

  // ---------------- output capture ----------------
  int cur_addr = 0, nrecv = 0, byte_err = 0, hold_err = 0;
  bit was_stall = 0;
  logic [7:0] stall_d = 8'h00;
  always @(posedge clk) begin
    if (was_stall && (!out_valid || out_data != stall_d)) hold_err++;
    was_stall = out_valid && !out_ready;
    stall_d   = out_data;
    if (out_valid && out_ready) begin
      if (out_data != pat((cur_addr + nrecv) >> 11, (cur_addr + nrecv) & 2047)) byte_err++;
      nrecv++;
    end
  end

  // ---------------- expectation ----------------
  bit exp_cv = 0;
  int exp_crow = 0;

  task automatic expect_req(input int a, input int l, output int st, output int loads, output int bytes);
    int row, col, rem, ch;
    bit fixed;
    row = a >> 11; col = a & 2047; rem = l; fixed = 0;
    st = 0; loads = 0; bytes = 0;
    if (l == 0) return;
    if (longint'(a) + l > (longint'(1) << 27)) begin st = 4; return; end
    while (rem > 0) begin
      if ((row >> 6) == 2 || (row >> 6) == 700) begin st = 3; return; end
      if (!(exp_cv && exp_crow == row)) begin
        loads++;
        if (row == STUCK_ROW) begin st = 5; exp_cv = 0; return; end
        if (ecc_of(row) == 2) begin st = 2; exp_cv = 0; return; end
        if (ecc_of(row) == 1) fixed = 1;
        exp_cv = 1; exp_crow = row;
      end
      ch = (rem < 2048 - col) ? rem : 2048 - col;
      bytes += ch; rem -= ch; row++; col = 0;
    end
    st = fixed ? 1 : 0;
  endtask

  function automatic string tag_of(input int st);
    case (st)
      1: return "R3";
      2: return "R4";
      3: return "R8";
      4: return "R10";
      5: return "R2";
      default: return "R6";
    endcase
  endfunction

  task automatic do_req(input int a, input int l, input string ltag);
    int es, el, eb, ld0, xb0;
    expect_req(a, l, es, el, eb);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_addr = a; nrecv = 0; byte_err = 0; ld0 = n_load; xb0 = n_xfer;
    req_valid = 1'b1; req_addr = 27'(a); req_len = 16'(l);
    @(negedge clk);
    req_valid = 1'b0;
    if (l == 0 || es == 4) begin
      chk(done === 1'b1, "R10", "done in cycle after accept", done, 1);
    end else begin
      chk(req_ready === 1'b0, "R13", "ready low while busy", req_ready, 0);
    end
    while (!done) @(negedge clk);
    chk(done_status == 3'(es), tag_of(es), "final status", done_status, es);
    @(negedge clk);
    chk(done === 1'b0, "R13", "done one cycle", done, 0);
    chk(n_load - ld0 == el, ltag, "page loads", n_load - ld0, el);
    chk(nrecv == eb, "R6", "byte count", nrecv, eb);
    if (eb > 0) chk(byte_err == 0, "R6", "byte values", byte_err, 0);
    if (l == 0 || es == 4) chk(n_xfer == xb0, "R10", "exchanges sent", n_xfer - xb0, 0);
  endtask

  task automatic pulse_inv();
    @(negedge clk); inv_row = 1'b1;
    @(negedge clk); inv_row = 1'b0;
    exp_cv = 0;
  endtask

  task automatic end_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    end_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(req_ready === 1'b1, "R13", "reset req_ready", req_ready, 1);
    chk(done === 1'b0 && out_valid === 1'b0, "R13", "reset done/out_valid", {done, out_valid}, 0);
    chk(xfer_valid === 1'b0, "R13", "reset xfer_valid", xfer_valid, 0);

    // R9: last row (all ones) after reset must load
    do_req((65535 << 11) + 100, 50, "R9");
    // R7: same row again, no load
    do_req((65535 << 11) + 300, 20, "R7");
    // R9: invalidate forces reload
    pulse_inv();
    do_req((65535 << 11) + 10, 5, "R9");
    // R6: crossing a page boundary
    do_req(2040, 20, "R6");
    // R3: corrected page
    do_req(FIX_ROW * 2048 + 5, 10, "R3");
    // R4: uncorrectable, then reload on retry
    do_req(BADECC_ROW * 2048, 8, "R4");
    do_req(BADECC_ROW * 2048 + 4, 8, "R4");
    // R4: clean row, then uncorrectable next row mid-request
    do_req(4 * 2048 + 2000, 100, "R4");
    // R8: bad block
    do_req(130 * 2048 + 7, 12, "R8");
    // R2: stuck busy
    do_req(STUCK_ROW * 2048, 4, "R2");
    // R10: zero length, range boundary
    do_req(1000, 0, "R10");
    do_req((1 << 27) - 10, 11, "R10");
    do_req((1 << 27) - 10, 10, "R10");

    // random mix
    for (int i = 0; i < 30; i++) begin
      int row, col, len;
      case ($urandom % 8)
        0, 1, 2, 3, 4: row = $urandom % 12;
        5: row = 128 + ($urandom % 64);
        6: row = 65535;
        default: row = $urandom % 2000;
      endcase
      col = $urandom % 2048;
      len = (($urandom % 10) == 0) ? 0 : ($urandom % 400);
      if (($urandom % 5) == 0) pulse_inv();
      do_req(row * 2048 + col, len, "R7");
    end

    repeat (5) @(negedge clk);
    chk(ferr_ld == 0, "R1", "page load frame errors", ferr_ld, 0);
    chk(ferr_pl == 0, "R2", "status poll frame errors", ferr_pl, 0);
    chk(ferr_rd == 0, "R5", "cache read frame errors", ferr_rd, 0);
    chk(r12_err == 0, "R12", "bytes offered while in flight", r12_err, 0);
    chk(hold_err == 0, "R11", "stalled output changed", hold_err, 0);
    end_run();
  end
endmodule